// File: doc/BRIEF.md
# Laser Fault and Shutdown Controller

This block decides when a burst-mode laser transmitter may drive modulation and bias current. It holds both outputs off after power-up until the supply is good and a first temperature conversion has finished. When the supply-low alarm is enabled, it also waits for that alarm to clear. It then turns modulation on first and issues a one-cycle start strobe to an external bias search engine before it reports bias as enabled. The transmit-disable pin and a software disable bit both shut the outputs off. Releasing them restarts the same modulation-then-bias order.

Two independently masked alarm paths watch a vector of slow (converted) alarms and a vector of fast comparator alarms. The fault pin follows its enabled alarms while they persist. Optionally it also follows the safety latch. The shutdown gate path latches on any alarm enabled in its own masks and forces modulation and bias off. Its idle level is chosen by a direction bit. The latch clears on a falling edge of the transmit-off request or on a software reset strobe, and only when no gate-enabled alarm is still active. Loss of supply-good cannot be masked: it drops the outputs and requires a fresh temperature conversion.

Top module: `laser_fault_ctrl`

## Requirements
- R1: After reset, modEn, biasEn and biasStart stay 0 until supplyGood is 1, a tempDone pulse has been seen, and (when supplyAlarmEn is 1) supplyLowAlarm is 0. modEn becomes 1 right after the clock edge at which all three hold.
- R2: Each enable sequence first gives one cycle with modEn=1, biasStart=1 and biasEn=0, then biasEn=1 and biasStart=0 from the next cycle on.
- R3: A 1 on txDisable or softDisable clears modEn and biasEn after one clock edge. Returning both to 0 re-enters the R2 sequence after one edge.
- R4: faultPin is 1 one edge after any slow alarm bit with its faultMaskSlow bit at 1, or any fast alarm bit with its faultMaskFast bit at 1, is active. It returns to 0 one edge after all such alarms drop. Alarms with a mask bit of 0 leave faultPin at 0.
- R5: With faultGateEn=1, a tripped gate latch drives faultPin to 1 in the same cycle the latch sets, and holds it there while the latch stays set, even with no fault-masked alarm.
- R6: An alarm enabled by gateMaskSlow or gateMaskFast sets the gate latch one edge later. The latch stays set after the alarm goes away. gatePin equals the latch state XOR gateDir, so with gateDir=0 it idles 0 and trips to 1, and with gateDir=1 it idles 1 and trips to 0.
- R7: While the gate latch is set, modEn, biasEn and biasStart are 0.
- R8: The latch clears at the edge where the transmit-off request (txDisable OR softDisable) falls, or where softGateReset is 1, but only if no gate-enabled alarm is active at that edge. After it clears with transmit-off released, the R2 sequence starts one edge later.
- R9: Dropping supplyGood clears modEn and biasEn after one edge whatever the masks are. After supplyGood returns, the outputs stay off until a new tempDone pulse.
- R10: status[1] is 1 while the gate latch is set and status[0] equals faultPin, independent of gateDir.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| supplyGood | input | 1 | Supply above power-on threshold |
| tempDone | input | 1 | Pulse when a temperature conversion completes |
| supplyLowAlarm | input | 1 | Converted supply-low alarm |
| supplyAlarmEn | input | 1 | Makes power-up wait on supplyLowAlarm |
| txDisable | input | 1 | Transmit-disable pin |
| softDisable | input | 1 | Software transmit disable |
| softGateReset | input | 1 | Software request to clear the gate latch |
| slowAlarms | input | NSLOW | Converted alarm flags |
| fastAlarms | input | NFAST | Fast comparator alarm flags |
| faultMaskSlow | input | NSLOW | Slow alarms that drive faultPin |
| faultMaskFast | input | NFAST | Fast alarms that drive faultPin |
| faultGateEn | input | 1 | Routes the gate latch into faultPin |
| gateMaskSlow | input | NSLOW | Slow alarms that trip the gate latch |
| gateMaskFast | input | NFAST | Fast alarms that trip the gate latch |
| gateDir | input | 1 | Idle level of gatePin |
| modEn | output | 1 | Modulation output enable |
| biasEn | output | 1 | Bias output enable |
| biasStart | output | 1 | One-cycle start of the bias search |
| faultPin | output | 1 | Transmit-fault output, active high |
| gatePin | output | 1 | Safety-shutdown gate output |
| status | output | 2 | {gate active, fault active} |

## Verification
Every result is registered once, so it is due right after the first rising edge following the stimulus. The exceptions are bias enable, which follows modulation by a further edge, and the re-enable after a latch clear, which trails the clear by one edge. The bench changes inputs on falling edges and reads outputs on the next falling edge, which places each check half a period after the edge that must produce the result. For two-step results it steps once more and also checks the intermediate value, for example modulation on with bias still off, or the latch cleared with modulation still off.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_MOD  = 3'd1,
    ST_RUN  = 3'd2,
    ST_OFF  = 3'd3,
    ST_TRIP = 3'd4
  } lfcState_e;

  typedef struct packed {
    logic gateClr;
  } lfcStrobe_t;
endpackage

// File: rtl/lfc_ctrl.sv
module lfc_ctrl
  import lfc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyGood,
  input  logic       tempDone,
  input  logic       supplyLowAlarm,
  input  logic       supplyAlarmEn,
  input  logic       txDisable,
  input  logic       softDisable,
  input  logic       softGateReset,
  input  logic       gateLatched,
  output lfcStrobe_t strb,
  output logic       modEn,
  output logic       biasEn,
  output logic       biasStart
);
  lfcState_e state, stateNext;
  logic tempSeen, txPrev, txOff, ready;

  assign txOff = txDisable | softDisable;
  assign ready = (tempSeen | tempDone) & ~(supplyAlarmEn & supplyLowAlarm);
  assign strb.gateClr = (txPrev & ~txOff) | softGateReset;

  always_comb begin
    stateNext = state;
    if (!supplyGood) begin
      stateNext = ST_WAIT;
    end else begin
      case (state)
        ST_WAIT: if (ready && !txOff && !gateLatched) stateNext = ST_MOD;
        ST_MOD:  if (txOff) stateNext = ST_OFF;
                 else if (gateLatched) stateNext = ST_TRIP;
                 else stateNext = ST_RUN;
        ST_RUN:  if (txOff) stateNext = ST_OFF;
                 else if (gateLatched) stateNext = ST_TRIP;
        ST_OFF:  if (!txOff) stateNext = gateLatched ? ST_TRIP : ST_MOD;
        ST_TRIP: if (txOff) stateNext = ST_OFF;
                 else if (!gateLatched) stateNext = ST_MOD;
        default: stateNext = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_WAIT;
      tempSeen <= 1'b0;
      txPrev   <= 1'b0;
    end else begin
      state  <= stateNext;
      txPrev <= txOff;
      if (!supplyGood) tempSeen <= 1'b0;
      else if (tempDone) tempSeen <= 1'b1;
    end
  end

  assign modEn     = ((state == ST_MOD) || (state == ST_RUN)) && !gateLatched;
  assign biasEn    = (state == ST_RUN) && !gateLatched;
  assign biasStart = (state == ST_MOD) && !gateLatched;

  AST_SUPPLY_DROP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !supplyGood |=> !modEn && !biasEn); // R9
  AST_TXOFF_OFF: assert property (@(posedge clk) disable iff (!rstN)
    txOff |=> !modEn && !biasEn); // R3
  AST_BIAS_AFTER_MOD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(biasEn) |-> $past(biasStart) && $past(modEn)); // R2
endmodule

// File: rtl/lfc_dp.sv
module lfc_dp
  import lfc_pkg::*;
#(
  parameter int NSLOW = 8,
  parameter int NFAST = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  lfcStrobe_t       strb,
  input  logic [NSLOW-1:0] slowAlarms,
  input  logic [NFAST-1:0] fastAlarms,
  input  logic [NSLOW-1:0] faultMaskSlow,
  input  logic [NFAST-1:0] faultMaskFast,
  input  logic             faultGateEn,
  input  logic [NSLOW-1:0] gateMaskSlow,
  input  logic [NFAST-1:0] gateMaskFast,
  input  logic             gateDir,
  output logic             gateLatched,
  output logic             faultPin,
  output logic             gatePin,
  output logic [1:0]       status
);
  logic gateTrip, faultTrip, gateNext, faultQ, gateQ;

  assign gateTrip  = |(slowAlarms & gateMaskSlow) | |(fastAlarms & gateMaskFast);
  assign faultTrip = |(slowAlarms & faultMaskSlow) | |(fastAlarms & faultMaskFast);
  // a fresh trip wins over a clear request in the same cycle
  assign gateNext  = gateTrip | (gateQ & ~strb.gateClr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateQ  <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      gateQ  <= gateNext;
      faultQ <= faultTrip | (faultGateEn & gateNext);
    end
  end

  assign gateLatched = gateQ;
  assign faultPin    = faultQ;
  assign gatePin     = gateQ ^ gateDir;
  assign status      = {gateQ, faultQ};

  AST_GATE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    gateTrip |=> gateLatched); // R6
  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (gateLatched && !strb.gateClr) |=> gateLatched); // R6
  AST_GATE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.gateClr && !gateTrip) |=> !gateLatched); // R8
  AST_FAULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    faultTrip |=> faultPin); // R4
endmodule

// File: rtl/laser_fault_ctrl.sv
module laser_fault_ctrl
  import lfc_pkg::*;
#(
  parameter int NSLOW = 8,
  parameter int NFAST = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             supplyGood,
  input  logic             tempDone,
  input  logic             supplyLowAlarm,
  input  logic             supplyAlarmEn,
  input  logic             txDisable,
  input  logic             softDisable,
  input  logic             softGateReset,
  input  logic [NSLOW-1:0] slowAlarms,
  input  logic [NFAST-1:0] fastAlarms,
  input  logic [NSLOW-1:0] faultMaskSlow,
  input  logic [NFAST-1:0] faultMaskFast,
  input  logic             faultGateEn,
  input  logic [NSLOW-1:0] gateMaskSlow,
  input  logic [NFAST-1:0] gateMaskFast,
  input  logic             gateDir,
  output logic             modEn,
  output logic             biasEn,
  output logic             biasStart,
  output logic             faultPin,
  output logic             gatePin,
  output logic [1:0]       status
);
  lfcStrobe_t strb;
  logic gateLatched;

  lfc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .tempDone(tempDone),
    .supplyLowAlarm(supplyLowAlarm), .supplyAlarmEn(supplyAlarmEn),
    .txDisable(txDisable), .softDisable(softDisable), .softGateReset(softGateReset),
    .gateLatched(gateLatched), .strb(strb), .modEn(modEn), .biasEn(biasEn),
    .biasStart(biasStart)
  );

  lfc_dp #(.NSLOW(NSLOW), .NFAST(NFAST)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .slowAlarms(slowAlarms),
    .fastAlarms(fastAlarms), .faultMaskSlow(faultMaskSlow),
    .faultMaskFast(faultMaskFast), .faultGateEn(faultGateEn),
    .gateMaskSlow(gateMaskSlow), .gateMaskFast(gateMaskFast), .gateDir(gateDir),
    .gateLatched(gateLatched), .faultPin(faultPin), .gatePin(gatePin),
    .status(status)
  );

  AST_TRIP_BLOCKS_OUTPUTS: assert property (@(posedge clk) disable iff (!rstN)
    status[1] |-> !modEn && !biasEn && !biasStart); // R7
endmodule

// File: tb/sim_laser_fault_ctrl.sv
module sim_laser_fault_ctrl;
  localparam int NSLOW = 8;
  localparam int NFAST = 4;

  logic clk = 1'b0;
  logic rstN, supplyGood, tempDone, supplyLowAlarm, supplyAlarmEn;
  logic txDisable, softDisable, softGateReset, faultGateEn, gateDir;
  logic [NSLOW-1:0] slowAlarms, faultMaskSlow, gateMaskSlow;
  logic [NFAST-1:0] fastAlarms, faultMaskFast, gateMaskFast;
  logic modEn, biasEn, biasStart, faultPin, gatePin;
  logic [1:0] status;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  laser_fault_ctrl #(.NSLOW(NSLOW), .NFAST(NFAST)) u0 (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .tempDone(tempDone),
    .supplyLowAlarm(supplyLowAlarm), .supplyAlarmEn(supplyAlarmEn),
    .txDisable(txDisable), .softDisable(softDisable), .softGateReset(softGateReset),
    .slowAlarms(slowAlarms), .fastAlarms(fastAlarms), .faultMaskSlow(faultMaskSlow),
    .faultMaskFast(faultMaskFast), .faultGateEn(faultGateEn),
    .gateMaskSlow(gateMaskSlow), .gateMaskFast(gateMaskFast), .gateDir(gateDir),
    .modEn(modEn), .biasEn(biasEn), .biasStart(biasStart), .faultPin(faultPin),
    .gatePin(gatePin), .status(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic doReset(input logic dir);
    @(negedge clk);
    rstN = 1'b0; supplyGood = 1'b0; tempDone = 1'b0; supplyLowAlarm = 1'b0;
    supplyAlarmEn = 1'b0; txDisable = 1'b0; softDisable = 1'b0; softGateReset = 1'b0;
    faultGateEn = 1'b0; gateDir = dir; slowAlarms = '0; fastAlarms = '0;
    faultMaskSlow = '0; faultMaskFast = '0; gateMaskSlow = '0; gateMaskFast = '0;
    step(); step();
    rstN = 1'b1;
    step();
  endtask

  task automatic powerUp();
    supplyGood = 1'b1; tempDone = 1'b1;
    step();
    tempDone = 1'b0;
    step();
  endtask

  task automatic t_reset();
    doReset(1'b0);
    check("R1 reset modEn", modEn, 0);
    check("R1 reset biasEn", biasEn, 0);
    check("R4 reset faultPin", faultPin, 0);
    check("R6 reset gatePin dir0", gatePin, 0);
    check("R10 reset status", status, 0);
    doReset(1'b1);
    check("R6 reset gatePin dir1", gatePin, 1);
  endtask

  task automatic t_powerup();
    doReset(1'b0);
    supplyGood = 1'b1;
    step(); step();
    check("R1 no temp yet", modEn, 0);
    supplyAlarmEn = 1'b1; supplyLowAlarm = 1'b1; tempDone = 1'b1;
    step();
    tempDone = 1'b0;
    step();
    check("R1 supply low blocks", modEn, 0);
    supplyLowAlarm = 1'b0;
    step();
    check("R2 mod first", modEn, 1);
    check("R2 start pulse", biasStart, 1);
    check("R2 bias not yet", biasEn, 0);
    step();
    check("R2 bias on", biasEn, 1);
    check("R2 start ends", biasStart, 0);
  endtask

  task automatic t_txdis();
    doReset(1'b0);
    powerUp();
    txDisable = 1'b1;
    step();
    check("R3 pin off mod", modEn, 0);
    check("R3 pin off bias", biasEn, 0);
    txDisable = 1'b0;
    step();
    check("R3 restart mod", modEn, 1);
    check("R3 restart start", biasStart, 1);
    check("R3 restart bias off", biasEn, 0);
    step();
    softDisable = 1'b1;
    step();
    check("R3 soft off", modEn, 0);
    softDisable = 1'b0;
    step(); step();
    check("R3 soft release", biasEn, 1);
  endtask

  task automatic t_fault();
    doReset(1'b0);
    powerUp();
    faultMaskSlow = 8'h01; faultMaskFast = 4'b0100;
    slowAlarms = 8'h02;
    step();
    check("R4 masked slow ignored", faultPin, 0);
    slowAlarms = 8'h01;
    step();
    check("R4 slow fault", faultPin, 1);
    check("R10 fault status", status, 2'b01);
    check("R4 no gate without mask", modEn, 1);
    slowAlarms = 8'h00;
    step();
    check("R4 fault follows", faultPin, 0);
    fastAlarms = 4'b0100;
    step();
    check("R4 fast fault", faultPin, 1);
    fastAlarms = 4'b0000;
    step();
    check("R4 fast drops", faultPin, 0);
  endtask

  task automatic t_gate_soft();
    doReset(1'b0);
    powerUp();
    gateMaskFast = 4'b0010;
    fastAlarms = 4'b0010;
    step();
    check("R6 gate trips", gatePin, 1);
    check("R7 mod forced off", modEn, 0);
    check("R10 gate status", status[1], 1);
    check("R4 fault not routed", faultPin, 0);
    fastAlarms = 4'b0000;
    step();
    check("R6 gate latched", gatePin, 1);
    check("R7 bias off", biasEn, 0);
    fastAlarms = 4'b0010; softGateReset = 1'b1;
    step();
    check("R8 clear blocked by alarm", gatePin, 1);
    fastAlarms = 4'b0000;
    step();
    softGateReset = 1'b0;
    check("R8 soft clear", gatePin, 0);
    check("R8 mod still off", modEn, 0);
    step();
    check("R8 restart mod", modEn, 1);
    check("R8 restart start", biasStart, 1);
  endtask

  task automatic t_gate_route();
    doReset(1'b1);
    powerUp();
    faultGateEn = 1'b1; gateMaskSlow = 8'h80;
    slowAlarms = 8'h80;
    step();
    check("R6 dir1 trip level", gatePin, 0);
    check("R5 routed fault", faultPin, 1);
    slowAlarms = 8'h00;
    step();
    check("R5 fault held by latch", faultPin, 1);
    txDisable = 1'b1;
    step();
    check("R8 no clear on rise", gatePin, 0);
    txDisable = 1'b0;
    step();
    check("R8 tx toggle clears", gatePin, 1);
    check("R5 fault released", faultPin, 0);
    step();
    check("R8 tx restart", modEn, 1);
  endtask

  task automatic t_supply();
    doReset(1'b0);
    powerUp();
    gateMaskSlow = '0; faultMaskSlow = '0;
    supplyGood = 1'b0;
    step();
    check("R9 drop off", modEn, 0);
    supplyGood = 1'b1;
    step(); step();
    check("R9 needs new temp", modEn, 0);
    tempDone = 1'b1;
    step();
    tempDone = 1'b0;
    check("R9 back on", modEn, 1);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_powerup();
    t_txdis();
    t_fault();
    t_gate_soft();
    t_gate_route();
    t_supply();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule